// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Read Engine

This block is the memory side of a single-lane serial NOR flash link. It follows the host's chip select, serial clock and data-in line, all sampled into the system clock domain, and returns read data on one serial output. A host first loads an 8-bit volatile setup register. Its upper nibble sets how many dummy clocks come between address and data. One bit of it arms execute-in-place (XIP) operation. A fast read that carries the right confirmation bit in its first dummy clock then switches the engine into XIP. While in XIP, every new chip-select frame is taken as a bare 24-bit address, with no opcode, followed by dummy clocks and streaming data.

The FSM has these states. ST_IDLE: chip select inactive. ST_OPC: collecting the command byte. ST_CFG: collecting the setup byte. ST_ADDR: collecting the 24-bit address. ST_DUMMY: counting dummy clocks and sampling the confirmation bit on the first one. ST_DATA: streaming bytes. ST_SKIP: ignoring the rest of a frame. The transitions are as follows. ST_IDLE→ST_ADDR when a frame starts in XIP, and ST_IDLE→ST_OPC otherwise. ST_OPC→ST_CFG on command 81h, ST_OPC→ST_ADDR on 0Bh, and ST_OPC→ST_SKIP on any other byte. ST_CFG→ST_SKIP after the setup byte. ST_ADDR→ST_DUMMY after 24 bits. ST_DUMMY→ST_DATA after the configured number of dummy clocks. Any state→ST_IDLE when chip select goes inactive.

Data flows in on rising serial clock edges and out on falling edges, most significant bit first. Each byte is fetched through a combinational memory read port. The parameter BASIC_ENTRY selects the variant that needs no arming.

Top module: `xip_read_engine`

## Requirements
- R1: After reset the setup register is FFh. The engine is then out of XIP and not armed, a fast read uses 15 dummy clocks, and sdo is 0.
- R2: Command byte 81h followed by one byte loads that byte into the setup register. Any further bits in the same frame have no effect.
- R3: The number of dummy clocks is setup bits [7:4]. A value of 0 gives one dummy clock.
- R4: Command 0Bh followed by a 24-bit address (MSB first) and the dummy clocks returns the bytes at address, address+1, and so on. Each byte is sent MSB first and each bit changes on a falling serial clock edge.
- R5: Clearing setup bit 3 (arming) does not by itself enter XIP, so the next frame is still decoded as a command.
- R6: With BASIC_ENTRY=0 and bit 3 clear, a fast read whose first dummy bit is 0 enters XIP. Later frames then carry a bare 24-bit address, and a 0 confirmation bit in such a frame keeps XIP.
- R7: With BASIC_ENTRY=0 and bit 3 set, a first dummy bit of 0 does not enter XIP.
- R8: In XIP, a first dummy bit of the opposite value (1 when BASIC_ENTRY=0) still completes the current read, and the next frame is decoded as a command again.
- R9: Raising chip select mid-frame abandons the frame but keeps both the setup register and the XIP state.
- R10: A command byte other than 81h or 0Bh causes the rest of the frame to be ignored, and sdo stays 0 outside the data phase.
- R11: With BASIC_ENTRY=1, a fast read whose first dummy bit is 1 enters XIP even when bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in, sampled on sck rise |
| mem_rdata | input | 8 | Byte at mem_addr, combinational |
| sdo | output | 1 | Serial data out, changes after sck fall |
| mem_rd | output | 1 | One-cycle strobe when a byte is taken |
| mem_addr | output | 24 | Current read address |

## Verification
The assertions assume that sck, sdi and cs_n change only on separate system clocks and stay stable for several system clocks, so that all three reach the logic through the synchronizer in their original order. They also assume the memory port answers in the same cycle. The bench therefore moves every serial pin on the falling system clock, holds each sck half period for six system clocks, and waits several clocks around every chip-select change. It also chooses XIP addresses whose top byte is neither 81h nor 0Bh, so that a copy of the engine that is outside XIP sees a plain ignored command.

// File: rtl/xip_pkg.sv
package xip_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_CFG,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } frame_st_e;

    localparam logic [7:0] OPC_CFG_WR  = 8'h81;
    localparam logic [7:0] OPC_FAST_RD = 8'h0B;
    localparam logic [7:0] CFG_RESET   = 8'hFF;
    localparam int         CFG_ARM_BIT = 3;
    localparam int         DUMMY_LSB   = 4;
    localparam int         DUMMY_W     = 4;
endpackage

// File: rtl/xip_sync.sv
module xip_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[g] <= RST_VAL;
            else if (g == 0) chain[g] <= d;
            else             chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xip_tx_shift.sv
module xip_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck_fall,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              ld
);
    localparam int BC_W = $clog2(DATA_W);

    logic [BC_W-1:0]   bcnt;
    logic [DATA_W-1:0] sr;

    assign ld = en && sck_fall && (bcnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo  <= 1'b0;
            bcnt <= '0;
            sr   <= '0;
        end else if (!en) begin
            sdo  <= 1'b0;
            bcnt <= '0;
            sr   <= '0;
        end else if (sck_fall) begin
            if (bcnt == '0) begin
                sdo <= rdata[DATA_W-1];
                sr  <= {rdata[DATA_W-2:0], 1'b0};
            end else begin
                sdo <= sr[DATA_W-1];
                sr  <= {sr[DATA_W-2:0], 1'b0};
            end
            bcnt <= bcnt + 1'b1;
        end
    end

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sdo); // R10
endmodule

// File: rtl/xip_frame_fsm.sv
module xip_frame_fsm
    import xip_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter bit BASIC_ENTRY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sdi_s,
    input  logic              ld_byte,
    output frame_st_e         state,
    output logic [ADDR_W-1:0] addr,
    output logic              xip_on
);
    localparam int   CNT_W    = $clog2(ADDR_W) + 1;
    localparam logic KEEP_BIT = BASIC_ENTRY;

    frame_st_e          nxt;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  sh;
    logic [7:0]         cfg;
    logic [7:0]         byte_in;
    logic [DUMMY_W-1:0] dummy_n;
    logic               counting;

    assign byte_in  = {sh[6:0], sdi_s};
    assign dummy_n  = (cfg[DUMMY_LSB +: DUMMY_W] == '0) ? DUMMY_W'(1)
                                                        : cfg[DUMMY_LSB +: DUMMY_W];
    assign counting = (state == ST_OPC) || (state == ST_CFG) ||
                      (state == ST_ADDR) || (state == ST_DUMMY);

    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = xip_on ? ST_ADDR : ST_OPC;
                ST_OPC:   if (sck_rise && cnt == CNT_W'(7)) begin
                              if (byte_in == OPC_CFG_WR)       nxt = ST_CFG;
                              else if (byte_in == OPC_FAST_RD) nxt = ST_ADDR;
                              else                             nxt = ST_SKIP;
                          end
                ST_CFG:   if (sck_rise && cnt == CNT_W'(7)) nxt = ST_SKIP;
                ST_ADDR:  if (sck_rise && cnt == CNT_W'(ADDR_W-1)) nxt = ST_DUMMY;
                ST_DUMMY: if (sck_rise && cnt == CNT_W'(dummy_n - 1'b1)) nxt = ST_DATA;
                ST_DATA:  nxt = ST_DATA;
                ST_SKIP:  nxt = ST_SKIP;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            cfg    <= CFG_RESET;
            addr   <= '0;
            xip_on <= 1'b0;
        end else begin
            if (!cs_act || nxt != state)   cnt <= '0;
            else if (sck_rise && counting) cnt <= cnt + 1'b1;

            if (sck_rise) sh <= {sh[ADDR_W-2:0], sdi_s};

            if (state == ST_CFG && sck_rise && cnt == CNT_W'(7))
                cfg <= byte_in;

            if (state == ST_ADDR && sck_rise && cnt == CNT_W'(ADDR_W-1))
                addr <= {sh[ADDR_W-2:0], sdi_s};
            else if (ld_byte)
                addr <= addr + 1'b1;

            if (state == ST_DUMMY && sck_rise && cnt == '0) begin
                if (xip_on) xip_on <= (sdi_s == KEEP_BIT);
                else        xip_on <= (sdi_s == KEEP_BIT) &&
                                      (BASIC_ENTRY || !cfg[CFG_ARM_BIT]);
            end
        end
    end

    AST_CFG_ONLY_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> ($past(state) == ST_CFG)); // R2

    AST_XIP_FIRST_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (xip_on != $past(xip_on)) |-> ($past(state) == ST_DUMMY && $past(cnt) == '0)); // R6

    AST_NO_ENTRY_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!BASIC_ENTRY && $rose(xip_on)) |-> !$past(cfg[CFG_ARM_BIT])); // R7

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0 && state == ST_IDLE)); // R9
endmodule

// File: rtl/xip_read_engine.sv
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit BASIC_ENTRY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sdo,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [2:0] pins_s;
    logic       cs_n_s, sck_s, sdi_s, sck_q;
    logic       sck_rise, sck_fall, ld;
    logic       xip_on;
    frame_st_e  state;

    xip_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, sdi}),
        .q     (pins_s)
    );

    assign {cs_n_s, sck_s, sdi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = sck_s && !sck_q;
    assign sck_fall = !sck_s && sck_q;

    xip_frame_fsm #(.ADDR_W(ADDR_W), .BASIC_ENTRY(BASIC_ENTRY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (!cs_n_s),
        .sck_rise (sck_rise),
        .sdi_s    (sdi_s),
        .ld_byte  (ld),
        .state    (state),
        .addr     (mem_addr),
        .xip_on   (xip_on)
    );

    xip_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state == ST_DATA),
        .sck_fall (sck_fall),
        .rdata    (mem_rdata),
        .sdo      (sdo),
        .ld       (ld)
    );

    assign mem_rd = ld;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_addr == $past(mem_addr) + 1'b1)); // R4
endmodule

// File: tb/xip_read_engine_tb.sv
module xip_read_engine_tb;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo_m, sdo_b, rd_m, rd_b;
    logic [23:0] addr_m, addr_b;
    logic [7:0]  rdata_m, rdata_b;
    int checks = 0, fails = 0;
    bit rd_phase = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] m;
        logic [7:0] b;
        bit         chk_b;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ (a[23:16] + 8'h5A);
    endfunction

    assign rdata_m = memf(addr_m);
    assign rdata_b = memf(addr_b);

    xip_read_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .mem_rdata(rdata_m), .sdo(sdo_m), .mem_rd(rd_m), .mem_addr(addr_m)
    );

    xip_read_engine #(.BASIC_ENTRY(1'b1)) u_dut_basic (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .mem_rdata(rdata_b), .sdo(sdo_b), .mem_rd(rd_b), .mem_addr(addr_b)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: collects bytes from both engines and compares with the queue
    initial begin
        logic [7:0] sm, sb;
        int n;
        sm = '0; sb = '0; n = 0;
        forever begin
            @(posedge sck);
            if (rd_phase) begin
                sm = {sm[6:0], sdo_m};
                sb = {sb[6:0], sdo_b};
                n++;
                if (n == 8) begin
                    n = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "unexpected byte", sm, 8'h00);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(sm === e.m, e.tag, sm, e.m);
                        if (e.chk_b) check(sb === e.b, {e.tag, " basic"}, sb, e.b);
                    end
                end
            end else begin
                n = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        tick(6);
    endtask

    task automatic cs_end();
        tick(4);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic wr_cfg(input logic [7:0] v, input bit extra);
        cs_begin();
        send_byte(8'h81);
        send_byte(v);
        if (extra) send_byte(8'hFF);
        cs_end();
    endtask

    task automatic data_bytes(input int nb);
        rd_phase = 1'b1;
        for (int i = 0; i < nb * 8; i++) send_bit(1'b0);
        rd_phase = 1'b0;
    endtask

    // Driver: one read frame, expected bytes pushed before clocking data
    task automatic rd_frame(input bit send_op, input logic [23:0] a, input logic conf,
                            input int nd, input int nb, input bit m_ok,
                            input bit b_chk, input bit b_ok, input string tag);
        cs_begin();
        if (send_op) send_byte(8'h0B);
        for (int i = 23; i >= 0; i--) send_bit(a[i]);
        send_bit(conf);
        for (int i = 1; i < nd; i++) send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            exp_t e;
            e.m = m_ok ? memf(a + 24'(i)) : 8'h00;
            e.b = b_ok ? memf(a + 24'(i)) : 8'h00;
            e.chk_b = b_chk;
            e.tag = tag;
            exp_q.push_back(e);
        end
        data_bytes(nb);
        cs_end();
    endtask

    task automatic junk_frame(input logic [7:0] opc, input int nb, input string tag);
        cs_begin();
        send_byte(opc);
        for (int i = 0; i < nb; i++) begin
            exp_t e;
            e.m = 8'h00; e.b = 8'h00; e.chk_b = 1'b1; e.tag = tag;
            exp_q.push_back(e);
        end
        data_bytes(nb);
        cs_end();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: idle output after reset
        check(sdo_m === 1'b0, "R1 sdo reset", {7'b0, sdo_m}, 8'h00);
        check(sdo_b === 1'b0, "R1 sdo reset basic", {7'b0, sdo_b}, 8'h00);

        // R1 default 15 dummies, R4 fast read data; R7 no entry when unarmed
        rd_frame(1'b1, 24'h123456, 1'b0, 15, 3, 1'b1, 1'b1, 1'b1, "R1 R4 default read");
        // R4 address increment across a 16-bit boundary
        rd_frame(1'b1, 24'h00FFFE, 1'b0, 15, 4, 1'b1, 1'b1, 1'b1, "R4 increment");
        // R7: bare-address frame must be decoded as command 3Ch and ignored
        rd_frame(1'b0, 24'h3C0010, 1'b0, 15, 2, 1'b0, 1'b1, 1'b0, "R7 no entry unarmed");

        // R2 with trailing byte ignored, R3 dummy count 3
        wr_cfg(8'h38, 1'b1);
        rd_frame(1'b1, 24'h0A0B0C, 1'b0, 3, 2, 1'b1, 1'b1, 1'b1, "R2 R3 cfg dummy 3");
        // R3: zero field gives one dummy clock
        wr_cfg(8'h08, 1'b0);
        rd_frame(1'b1, 24'h777777, 1'b0, 1, 2, 1'b1, 1'b1, 1'b1, "R3 zero dummy");

        // R5: arm only; bare-address frame still ignored
        wr_cfg(8'h60, 1'b0);
        rd_frame(1'b0, 24'h2A0000, 1'b0, 6, 2, 1'b0, 1'b1, 1'b0, "R5 arm only");

        // R6: confirm entry, then bare-address frames
        rd_frame(1'b1, 24'h000100, 1'b0, 6, 2, 1'b1, 1'b0, 1'b0, "R6 entry read");
        rd_frame(1'b0, 24'h400200, 1'b0, 6, 3, 1'b1, 1'b0, 1'b0, "R6 xip frame");

        // R9: abort mid-address, XIP and dummy count kept
        cs_begin();
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        cs_end();
        rd_frame(1'b0, 24'h400300, 1'b0, 6, 2, 1'b1, 1'b0, 1'b0, "R9 after abort");

        // R8: exit bit; current read completes, next bare frame ignored
        rd_frame(1'b0, 24'h410000, 1'b1, 6, 2, 1'b1, 1'b0, 1'b0, "R8 exit read");
        rd_frame(1'b0, 24'h420000, 1'b0, 6, 2, 1'b0, 1'b0, 1'b0, "R8 after exit");

        // R10: unknown command, output stays low
        junk_frame(8'h9F, 2, "R10 unknown opcode");

        // R11: basic variant enters on 1 without arming; default variant does not
        wr_cfg(8'h68, 1'b0);
        rd_frame(1'b1, 24'h000200, 1'b1, 6, 2, 1'b1, 1'b1, 1'b1, "R11 entry read");
        rd_frame(1'b0, 24'h550020, 1'b1, 6, 3, 1'b0, 1'b1, 1'b1, "R11 basic xip");

        tick(10);
        check(exp_q.size() == 0, "R4 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        finish_run();
    end
endmodule